// File: doc/BRIEF.md
# RAM Address Register Pair Bank with Shadow Swap

This block keeps the two address registers that a small 4-bit processor core uses to reach its data RAM. The file register selects one RAM file; the digit register selects one digit inside that file and also picks the single-bit discrete I/O line. Each of the two address registers has a shadow twin. A one-cycle swap moves the working value into the twin and brings the parked value back, so the twin serves as a one-deep stack slot. Read together with the working value, it also widens the reachable RAM address space.

Either working register can be written from the 4-bit ALU result bus. The digit register can also count up or down by one in the same cycle as a bus transfer. A loop over several digits can therefore step to the next digit without spending an instruction cycle on it. When the counter rolls over the top or bottom of its range, a wrap flag is raised during the commanding cycle, so decode can end such loops. All four registers sit on the same clock and share a synchronous reset. Outputs are the two working values and one concatenated extended address that also carries both shadow values.

Top module: `ram_addr_regs`

## Requirements
- R1: When `rst` is high at a rising clock edge, the file register, the digit register and both shadow registers read 0 afterwards. This holds whatever the other inputs are doing.
- R2: When `ld_x` is high, the file register takes `alu_res` at the next edge. The file shadow keeps its value.
- R3: When `swp_x` is high and `ld_x` is low, the file register and its shadow exchange contents at one edge.
- R4: When `ld_x` and `swp_x` are high together, the load takes effect and the swap is ignored. The file shadow is left unchanged.
- R5: When `ld_y` is high, the digit register takes `alu_res` at the next edge. The digit shadow keeps its value.
- R6: When `swp_y` is high and `ld_y` is low, the digit register and its shadow exchange contents at one edge.
- R7: When `ld_y` and `swp_y` are high together, the load takes effect and the swap is ignored. The digit shadow is left unchanged.
- R8: With `ld_y` and `swp_y` low, the digit register responds to the count inputs as follows:
  - `y_inc` high and `y_dec` low adds 1 modulo 2^DW.
  - `y_dec` high and `y_inc` low subtracts 1 modulo 2^DW.
  - Both high or both low holds the value.
- R9: `y_wrap` is a combinational output. It is high during a cycle exactly when an effective increment finds the digit register at 2^DW-1, or an effective decrement finds it at 0. It is low otherwise.
- R10: A count request is ignored in any cycle where `ld_y` or `swp_y` is high.
- R11: `file_addr` shows the file register and `digit_addr` shows the digit register. `ext_addr` is laid out as follows:
  - bits [4DW-1:3DW]: file shadow
  - bits [3DW-1:2DW]: file register
  - bits [2DW-1:DW]: digit shadow
  - bits [DW-1:0]: digit register
- R12: The two pairs are independent. With `ld_x` and `swp_x` low, the file register and its shadow hold their values whatever happens on the digit pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| alu_res | input | DW | ALU result bus used as load data |
| ld_x | input | 1 | Load file register from `alu_res` |
| swp_x | input | 1 | Exchange file register with its shadow |
| ld_y | input | 1 | Load digit register from `alu_res` |
| swp_y | input | 1 | Exchange digit register with its shadow |
| y_inc | input | 1 | Count digit register up |
| y_dec | input | 1 | Count digit register down |
| file_addr | output | DW | Current file register (RAM file select) |
| digit_addr | output | DW | Current digit register (RAM digit and discrete I/O select) |
| ext_addr | output | 4*DW | Concatenated shadow and working values |
| y_wrap | output | 1 | Digit counter rolls over in this cycle |

## Verification
The bench builds the block with the default DW of 4, so every register holds one of sixteen values and a modulo-16 model in the bench describes it completely. A sweep steps through all 64 combinations of the six command inputs against sixteen varying load values. This puts every priority conflict (load against swap, count against load or swap, increment against decrement) together with many register contents within reach. Directed runs then drive the counter across both rollover points and hold it at both ends, so the wrap flag is seen at 15 and at 0.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // Opposing requests cancel; a single request picks the direction.
  function automatic step_e decode_step(input logic inc, input logic dec);
    if (inc && !dec)      return STEP_UP;
    else if (dec && !inc) return STEP_DOWN;
    else                  return STEP_NONE;
  endfunction

endpackage

// File: rtl/ras_cnt_step.sv
module ras_cnt_step #(
  parameter int DW = 4
) (
  input  logic [DW-1:0]   cur,
  input  ras_pkg::step_e  step,
  output logic [DW-1:0]   nxt,
  output logic            wrap
);
  import ras_pkg::*;

  function automatic logic at_top(input logic [DW-1:0] v);
    return &v;
  endfunction

  function automatic logic at_bottom(input logic [DW-1:0] v);
    return ~|v;
  endfunction

  function automatic logic [DW-1:0] step_up(input logic [DW-1:0] v);
    return v + {{(DW-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [DW-1:0] step_down(input logic [DW-1:0] v);
    return v - {{(DW-1){1'b0}}, 1'b1};
  endfunction

  always_comb begin
    nxt  = cur;
    wrap = 1'b0;
    case (step)
      STEP_UP: begin
        nxt  = step_up(cur);
        wrap = at_top(cur);
      end
      STEP_DOWN: begin
        nxt  = step_down(cur);
        wrap = at_bottom(cur);
      end
      default: begin
        nxt  = cur;
        wrap = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/ras_addr_pair.sv
module ras_addr_pair #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic          swap_en,
  input  logic          step_en,
  input  logic [DW-1:0] load_val,
  input  logic [DW-1:0] step_val,
  output logic [DW-1:0] prim_q,
  output logic [DW-1:0] shad_q,
  output logic          swap_evt
);

  // Load outranks swap; stepping is gated upstream.
  assign swap_evt = swap_en && !load_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      prim_q <= '0;
      shad_q <= '0;
    end else if (load_en) begin
      prim_q <= load_val;
    end else if (swap_evt) begin
      prim_q <= shad_q;
      shad_q <= prim_q;
    end else if (step_en) begin
      prim_q <= step_val;
    end
  end

endmodule

// File: rtl/ram_addr_regs.sv
module ram_addr_regs #(
  parameter int DW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   alu_res,
  input  logic            ld_x,
  input  logic            swp_x,
  input  logic            ld_y,
  input  logic            swp_y,
  input  logic            y_inc,
  input  logic            y_dec,
  output logic [DW-1:0]   file_addr,
  output logic [DW-1:0]   digit_addr,
  output logic [4*DW-1:0] ext_addr,
  output logic            y_wrap
);
  import ras_pkg::*;

  localparam int NPAIR = 2;
  localparam int IDX_X = 0;
  localparam int IDX_Y = 1;
  localparam int SLICE = 2 * DW;

  logic          load_en  [NPAIR];
  logic          swap_en  [NPAIR];
  logic          step_en  [NPAIR];
  logic [DW-1:0] step_val [NPAIR];
  logic [DW-1:0] prim_q   [NPAIR];
  logic [DW-1:0] shad_q   [NPAIR];
  logic          swap_w   [NPAIR];

  // Named events for the checker.
  logic          x_swap_evt;
  logic          y_swap_evt;
  logic          y_step_evt;
  step_e         y_step_req;
  step_e         y_step_eff;
  logic [DW-1:0] y_step_nxt;

  assign load_en[IDX_X] = ld_x;
  assign swap_en[IDX_X] = swp_x;
  assign load_en[IDX_Y] = ld_y;
  assign swap_en[IDX_Y] = swp_y;

  // Counter: effective only when the digit pair is neither loaded nor swapped.
  assign y_step_req = decode_step(y_inc, y_dec);
  assign y_step_evt = (y_step_req != STEP_NONE) && !ld_y && !swp_y;
  assign y_step_eff = y_step_evt ? y_step_req : STEP_NONE;

  ras_cnt_step #(.DW(DW)) u_ystep (
    .cur  (prim_q[IDX_Y]),
    .step (y_step_eff),
    .nxt  (y_step_nxt),
    .wrap (y_wrap)
  );

  assign step_en[IDX_X]  = 1'b0;
  assign step_val[IDX_X] = '0;
  assign step_en[IDX_Y]  = y_step_evt;
  assign step_val[IDX_Y] = y_step_nxt;

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    ras_addr_pair #(.DW(DW)) u_pair (
      .clk      (clk),
      .rst      (rst),
      .load_en  (load_en[g]),
      .swap_en  (swap_en[g]),
      .step_en  (step_en[g]),
      .load_val (alu_res),
      .step_val (step_val[g]),
      .prim_q   (prim_q[g]),
      .shad_q   (shad_q[g]),
      .swap_evt (swap_w[g])
    );
    // Pair 0 lands in the top slice, the last pair in the bottom slice.
    assign ext_addr[(NPAIR-1-g)*SLICE +: DW]      = prim_q[g];
    assign ext_addr[(NPAIR-1-g)*SLICE + DW +: DW] = shad_q[g];
  end

  assign x_swap_evt = swap_w[IDX_X];
  assign y_swap_evt = swap_w[IDX_Y];
  assign file_addr  = prim_q[IDX_X];
  assign digit_addr = prim_q[IDX_Y];

endmodule

// File: rtl/ras_addr_chk.sv
module ras_addr_chk #(
  parameter int DW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [DW-1:0]   alu_res,
  input logic            ld_x,
  input logic            swp_x,
  input logic            ld_y,
  input logic            swp_y,
  input logic            y_inc,
  input logic            y_dec,
  input logic [DW-1:0]   file_addr,
  input logic [DW-1:0]   digit_addr,
  input logic [4*DW-1:0] ext_addr,
  input logic            y_wrap,
  input logic            x_swap_evt,
  input logic            y_swap_evt,
  input logic            y_step_evt
);

  logic [DW-1:0] spx_v;
  logic [DW-1:0] spy_v;
  assign spx_v = ext_addr[4*DW-1:3*DW];
  assign spy_v = ext_addr[2*DW-1:DW];

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (ext_addr == '0)); // R1

  AST_X_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld_x |=> (file_addr == $past(alu_res))); // R2

  AST_X_SWAP: assert property (@(posedge clk) disable iff (rst)
    x_swap_evt |=> (file_addr == $past(spx_v)) && (spx_v == $past(file_addr))); // R3

  AST_X_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (ld_x && swp_x) |=> $stable(spx_v)); // R4

  AST_Y_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld_y |=> (digit_addr == $past(alu_res)) && $stable(spy_v)); // R5

  AST_Y_SWAP: assert property (@(posedge clk) disable iff (rst)
    y_swap_evt |=> (digit_addr == $past(spy_v)) && (spy_v == $past(digit_addr))); // R6

  AST_Y_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (ld_y && swp_y) |-> !y_swap_evt); // R7

  AST_Y_COUNT_UP: assert property (@(posedge clk) disable iff (rst)
    (y_step_evt && y_inc) |=> (digit_addr == DW'($past(digit_addr) + 1'b1))); // R8

  AST_Y_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (y_step_evt && y_dec) |=> (digit_addr == DW'($past(digit_addr) - 1'b1))); // R8

  AST_Y_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ld_y && !swp_y && (y_inc == y_dec)) |=> $stable(digit_addr) && $stable(spy_v)); // R8

  AST_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
    (y_wrap && y_inc) |=> (digit_addr == '0)); // R9

  AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (y_wrap && y_dec) |=> (digit_addr == '1)); // R9

  AST_COUNT_GATED: assert property (@(posedge clk) disable iff (rst)
    (ld_y || swp_y) |-> !y_step_evt && !y_wrap); // R10

  AST_X_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!ld_x && !swp_x) |=> $stable(file_addr) && $stable(spx_v)); // R12

endmodule

bind ram_addr_regs ras_addr_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .alu_res    (alu_res),
  .ld_x       (ld_x),
  .swp_x      (swp_x),
  .ld_y       (ld_y),
  .swp_y      (swp_y),
  .y_inc      (y_inc),
  .y_dec      (y_dec),
  .file_addr  (file_addr),
  .digit_addr (digit_addr),
  .ext_addr   (ext_addr),
  .y_wrap     (y_wrap),
  .x_swap_evt (x_swap_evt),
  .y_swap_evt (y_swap_evt),
  .y_step_evt (y_step_evt)
);

// File: tb/ram_addr_regs_bench.sv
module ram_addr_regs_bench;

  localparam int DW  = 4;
  localparam int MOD = 1 << DW;

  logic            clk = 1'b0;
  logic            rst;
  logic [DW-1:0]   alu_res;
  logic            ld_x, swp_x, ld_y, swp_y, y_inc, y_dec;
  logic [DW-1:0]   file_addr, digit_addr;
  logic [4*DW-1:0] ext_addr;
  logic            y_wrap;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  int mx = 0, msx = 0, my = 0, msy = 0;

  always #2 clk = ~clk;

  ram_addr_regs #(.DW(DW)) u_ram_addr_regs (
    .clk(clk), .rst(rst), .alu_res(alu_res),
    .ld_x(ld_x), .swp_x(swp_x), .ld_y(ld_y), .swp_y(swp_y),
    .y_inc(y_inc), .y_dec(y_dec),
    .file_addr(file_addr), .digit_addr(digit_addr),
    .ext_addr(ext_addr), .y_wrap(y_wrap)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ext_model();
    return (msx << (3*DW)) | (mx << (2*DW)) | (msy << DW) | my;
  endfunction

  task automatic check_state(input string tx, input string ty);
    check(tx, int'(file_addr), mx);
    check(ty, int'(digit_addr), my);
    check("R11 extended address", int'(ext_addr), ext_model());
  endtask

  // Called one unit after a rising edge; returns one unit after the next.
  task automatic cycle(input int a, input bit lx, input bit sx, input bit ly,
                       input bit sy, input bit yi, input bit yd);
    int nmx, nmsx, nmy, nmsy;
    bit ei, ed;
    string tx, ty;
    alu_res = DW'(a);
    ld_x = lx; swp_x = sx; ld_y = ly; swp_y = sy; y_inc = yi; y_dec = yd;
    #1;
    ei = !ly && !sy && yi && !yd;
    ed = !ly && !sy && yd && !yi;
    check("R9 wrap flag", int'(y_wrap), int'((ei && my == MOD-1) || (ed && my == 0)));
    nmx = mx; nmsx = msx; nmy = my; nmsy = msy;
    if (lx) nmx = a % MOD;
    else if (sx) begin nmx = msx; nmsx = mx; end
    if (ly) nmy = a % MOD;
    else if (sy) begin nmy = msy; nmsy = my; end
    else if (ei) nmy = (my + 1) % MOD;
    else if (ed) nmy = (my + MOD - 1) % MOD;
    tx = lx ? (sx ? "R4 file load over swap" : "R2 file load")
            : (sx ? "R3 file swap" : "R12 file idle");
    if (ly)      ty = sy ? "R7 digit load over swap" : ((yi || yd) ? "R10 digit load over count" : "R5 digit load");
    else if (sy) ty = (yi || yd) ? "R10 digit swap over count" : "R6 digit swap";
    else         ty = (ei || ed) ? "R8 digit count" : "R8 digit hold";
    @(posedge clk); #1;
    mx = nmx; msx = nmsx; my = nmy; msy = nmsy;
    check_state(tx, ty);
  endtask

  task automatic do_reset();
    rst = 1'b1; alu_res = DW'(5); ld_x = 1'b1; swp_x = 1'b1;
    ld_y = 1'b1; swp_y = 1'b0; y_inc = 1'b1; y_dec = 1'b0;
    @(posedge clk); #1;
    rst = 1'b0;
    mx = 0; msx = 0; my = 0; msy = 0;
    check("R1 reset file", int'(file_addr), 0);
    check("R1 reset digit", int'(digit_addr), 0);
    check("R1 reset ext", int'(ext_addr), 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; alu_res = '0;
    ld_x = 0; swp_x = 0; ld_y = 0; swp_y = 0; y_inc = 0; y_dec = 0;
    @(posedge clk); #1;
    do_reset();
    // Sweep: all 64 command patterns against varying load data.
    for (int i = 0; i < 1024; i++) begin
      int c;
      c = i % 64;
      cycle((i / 64 + i * 5 + 3) % MOD, c[0], c[1], c[2], c[3], c[4], c[5]);
    end
    // R9 directed: wrap at the top and at the bottom.
    cycle(MOD-1, 0, 0, 1, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 1, 0);
    cycle(0, 0, 0, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 0, 1, 1);
    for (int k = 0; k < 20; k++) cycle(k, 0, 0, 0, 0, 0, 1);
    for (int k = 0; k < 20; k++) cycle(k, 0, 0, 0, 0, 1, 0);
    // R10 directed: count at the top ignored under load and swap.
    cycle(MOD-1, 0, 0, 1, 0, 0, 0);
    cycle(3, 0, 0, 1, 0, 1, 0);
    cycle(MOD-1, 0, 0, 1, 0, 0, 0);
    cycle(2, 0, 0, 0, 1, 1, 0);
    // R1 again from a non-zero state.
    cycle(9, 1, 0, 1, 0, 0, 0);
    cycle(6, 0, 1, 0, 1, 0, 0);
    do_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule